// File: doc/BRIEF.md
# Vector Lane Permute and Broadcast Unit

This block rearranges the contents of a 128-bit vector. It does one of three things in each cycle. It can reorder the four 32-bit lanes under an 8-bit immediate, and a source lane may be picked for more than one destination. It can rebuild the vector byte by byte, with each destination byte taken from a source position that a second vector supplies, and an index byte can force its destination byte to zero. It can also copy one 32-bit scalar into every lane. A fourth select code produces zeros.

The result passes through one register stage. A valid flag travels with it and lags the input valid by one cycle. The register loads only when the input valid is high, so the previous result stays on the output during idle cycles. A vector datapath places the unit between its operand read and its writeback.

Top module: `vec_permute`

## Requirements
- R1: While rst_n is low, out_valid is 0 and out_vec is all zeros.
- R2: out_valid equals the value in_valid had on the previous clock edge.
- R3: On an edge where in_valid is high, out_vec loads the result selected by op_sel. On an edge where in_valid is low, out_vec keeps its value.
- R4: When op_sel is 0, destination lane k (out_vec bits 32k+31:32k, k = 0..3) receives source lane imm[2k+1:2k]. Any source lane may feed several destination lanes.
- R5: Lane 0 sits in bits 31:0. With source lanes 0..3 = 10, 20, 30, 40 and imm = 8'hB1, destination lanes 0..3 are 20, 10, 40, 30.
- R6: When op_sel is 1, destination byte i (bits 8i+7:8i) receives the source byte at position idx_vec[8i+3:8i]. Example: source bytes 10, 20, ..., 160 and indices 2,2,2,2,3,3,3,3,0,0,0,0,1,1,1,1 give 30,30,30,30,40,40,40,40,10,10,10,10,20,20,20,20.
- R7: In the byte mode, if bit 7 of index byte i is 1, destination byte i is 0. Index bits 6:4 have no effect.
- R8: When op_sel is 2, all four lanes of the result equal scalar.
- R9: When op_sel is 3, the result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are valid this cycle |
| op_sel | input | 2 | 0 lane shuffle, 1 byte shuffle, 2 broadcast, 3 zero |
| src_vec | input | 128 | Source vector |
| idx_vec | input | 128 | Per-byte index vector for the byte shuffle |
| imm | input | 8 | Lane selector, 2 bits per destination lane |
| scalar | input | 32 | Value for broadcast |
| out_valid | output | 1 | Result valid |
| out_vec | output | 128 | Registered result |

## Verification
The bench applies all 256 immediates to a vector whose lanes are distinct. A reversed selector field, or lane 0 placed at the wrong end, therefore produces a visibly permuted mismatch, and the 8'hB1 case pins down the ordering. Random byte indices with bit 7 set about half the time and with random bits 6:4 catch a missing zeroing rule and an index decoder that reads too many bits, because either fault pulls wrong or out-of-range bytes into the output. Idle cycles between operations show whether the register reloads when it should hold, and the select code 3 shows whether a mux leaks stale or broadcast data.

// File: rtl/vec_permute.sv
module vec_permute #(
  parameter int LANES  = 4,
  parameter int LANE_W = 32,
  localparam int VW     = LANES * LANE_W,
  localparam int NBYTES = VW / 8,
  localparam int SEL_W  = $clog2(LANES),
  localparam int IMM_W  = LANES * SEL_W,
  localparam int BIX_W  = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op_sel,
  input  logic [VW-1:0]     src_vec,
  input  logic [VW-1:0]     idx_vec,
  input  logic [IMM_W-1:0]  imm,
  input  logic [LANE_W-1:0] scalar,
  output logic              out_valid,
  output logic [VW-1:0]     out_vec
);

  logic [VW-1:0] lane_res, byte_res, bcast_res, result;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SEL_W-1:0] pick;
    assign pick = imm[l*SEL_W +: SEL_W];
    assign lane_res[l*LANE_W +: LANE_W] = src_vec[pick*LANE_W +: LANE_W];
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [7:0] ix;
    logic       unused_mid;
    assign ix = idx_vec[b*8 +: 8];
    assign unused_mid = ^ix[6:BIX_W];
    assign byte_res[b*8 +: 8] = ix[7] ? 8'h00 : src_vec[ix[BIX_W-1:0]*8 +: 8];
  end

  assign bcast_res = {LANES{scalar}};

  always_comb begin
    case (op_sel)
      2'd0:    result = lane_res;
      2'd1:    result = byte_res;
      2'd2:    result = bcast_res;
      default: result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_vec <= result;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_vec == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_vec));

  // R7
  byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd1 && idx_vec[7]) |=> out_vec[7:0] == 8'h00);

  // R8
  bcast_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd2) |=> out_vec[LANE_W-1:0] == $past(scalar)
      && out_vec[VW-1 -: LANE_W] == $past(scalar));

  // R9
  zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd3) |=> out_vec == '0);

endmodule

// File: tb/vec_permute_bench.sv
`timescale 1ns/1ps
module vec_permute_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   op_sel;
  logic [127:0] src_vec, idx_vec;
  logic [7:0]   imm;
  logic [31:0]  scalar;
  logic         out_valid;
  logic [127:0] out_vec;

  int n_cmp = 0;
  int n_bad = 0;
  logic         exp_valid;
  logic [127:0] exp_vec;

  always #2.5 clk = ~clk;

  vec_permute u_vec_permute (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .src_vec(src_vec), .idx_vec(idx_vec), .imm(imm), .scalar(scalar),
    .out_valid(out_valid), .out_vec(out_vec)
  );

  function automatic logic [127:0] model(input logic [1:0] op, input logic [127:0] s,
                                         input logic [127:0] ix, input logic [7:0] im,
                                         input logic [31:0] sc);
    logic [127:0] r;
    r = '0;
    case (op)
      2'd0: for (int k = 0; k < 4; k++) begin
              int p;
              p = (im >> (2*k)) & 3;
              r[32*k +: 32] = s[32*p +: 32];
            end
      2'd1: for (int i = 0; i < 16; i++) begin
              logic [7:0] b;
              b = ix[8*i +: 8];
              r[8*i +: 8] = b[7] ? 8'h00 : s[8*int'(b[3:0]) +: 8];
            end
      2'd2: r = {4{sc}};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag);
    n_cmp++;
    if (out_valid !== exp_valid || out_vec !== exp_vec) begin
      n_bad++;
      $display("FAIL %s: actual valid=%b vec=%h expected valid=%b vec=%h",
               tag, out_valid, out_vec, exp_valid, exp_vec);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] op, input logic [127:0] s,
                      input logic [127:0] ix, input logic [7:0] im,
                      input logic [31:0] sc, input string tag);
    in_valid = v; op_sel = op; src_vec = s; idx_vec = ix; imm = im; scalar = sc;
    exp_valid = v;
    if (v) exp_vec = model(op, s, ix, im, sc);
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic lit_check(input string tag, input logic [127:0] want);
    n_cmp++;
    if (out_vec !== want) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, out_vec, want);
    end
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] lanes4, bytes16, ex_idx, ex_out;
    rst_n = 1'b0; in_valid = 1'b1; op_sel = 2'd2; src_vec = '0; idx_vec = '0;
    imm = '0; scalar = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    exp_valid = 1'b0; exp_vec = '0;
    check("R1 reset");
    in_valid = 1'b0;
    rst_n = 1'b1;

    lanes4 = {32'd40, 32'd30, 32'd20, 32'd10};
    step(1'b1, 2'd0, lanes4, '0, 8'hB1, '0, "R5 imm B1");
    lit_check("R5 literal", {32'd30, 32'd40, 32'd10, 32'd20});

    for (int i = 0; i < 256; i++)
      step(1'b1, 2'd0, lanes4, rnd128(), 8'(i), $urandom, "R4 exhaustive imm");
    for (int i = 0; i < 64; i++)
      step(1'b1, 2'd0, rnd128(), rnd128(), 8'($urandom), $urandom, "R4 random src");

    for (int i = 0; i < 16; i++) bytes16[8*i +: 8] = 8'(10*(i+1));
    for (int i = 0; i < 16; i++) begin
      int pat;
      pat = (i < 4) ? 2 : (i < 8) ? 3 : (i < 12) ? 0 : 1;
      ex_idx[8*i +: 8] = 8'(pat);
      ex_out[8*i +: 8] = 8'(10*(pat+1));
    end
    step(1'b1, 2'd1, bytes16, ex_idx, '0, '0, "R6 example");
    lit_check("R6 literal", ex_out);

    step(1'b1, 2'd1, rnd128(), {16{8'h80}}, '0, '0, "R7 all zeroed");
    lit_check("R7 literal zero", '0);
    step(1'b1, 2'd1, bytes16, {16{8'h75}}, '0, '0, "R7 mid bits ignored");
    lit_check("R7 literal 0x75", {16{8'd60}});
    for (int i = 0; i < 200; i++)
      step(1'b1, 2'd1, rnd128(), rnd128(), 8'($urandom), $urandom, "R6/R7 random idx");

    step(1'b1, 2'd2, rnd128(), rnd128(), 8'($urandom), 32'h12345678, "R8 broadcast");
    lit_check("R8 literal", {4{32'h12345678}});
    for (int i = 0; i < 20; i++)
      step(1'b1, 2'd2, rnd128(), rnd128(), 8'($urandom), $urandom, "R8 broadcast rnd");

    step(1'b1, 2'd3, rnd128(), rnd128(), 8'hFF, $urandom, "R9 zero op");
    lit_check("R9 literal", '0);

    step(1'b1, 2'd2, '0, '0, '0, 32'hA5A5A5A5, "R8 before idle");
    for (int i = 0; i < 5; i++)
      step(1'b0, 2'($urandom), rnd128(), rnd128(), 8'($urandom), $urandom, "R2/R3 idle hold");
    for (int i = 0; i < 100; i++)
      step(1'($urandom), 2'($urandom), rnd128(), rnd128(), 8'($urandom), $urandom,
           "R2/R3 mixed");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule